// File: doc/BRIEF.md
# Chained Watchpoint and Counter Unit

This block turns a vector of eight matchpoint hits into ten watchpoint flags for a processor debug unit. Each watchpoint has a two-bit chain code that passes its own source through, or ANDs or ORs it with the watchpoint just below it, so conditions can be built up serially along the chain. The first eight watchpoints are sourced by the matchpoints. The last two are sourced by a pair of 16-bit event counters: each one flags when its count equals its match value, judged after the counts have taken the current event's increment.

The surrounding debug logic presents one evaluation per `hit_valid_i` strobe. It supplies the chain codes, the counter enables, a per-watchpoint counter assignment and the generate-break enables. The block keeps the counters, sets sticky status bits for watchpoints that are asserted and enabled for break, and raises a one-cycle break request. Software loads the counters through a write port and clears status bits by writing ones.

Top module: `wp_chain_unit`

## Requirements
- R1: Watchpoint n for n in 1..7 takes its code from `chain_i[2n+1:2n]`. Code 00 gives matchpoint n alone, 01 gives matchpoint n AND watchpoint n-1, 10 gives matchpoint n OR watchpoint n-1, and 11 gives 0.
- R2: Watchpoint 0 (code at `chain_i[1:0]`) equals matchpoint 0 when its code is 00, and 0 for every other code.
- R3: On an evaluated event, each counter whose `cnt_en_i` bit is set rises by the number of asserted watchpoints among 0..7 assigned to it. `cnt_sel_i[n]`=0 assigns watchpoint n to counter 0 (count on `cnt_count_o[15:0]`) and 1 assigns it to counter 1 (`cnt_count_o[31:16]`). A disabled counter keeps its value.
- R4: Watchpoint 8 is sourced by counter 0 matched and watchpoint 9 by counter 1 matched, with chain codes at `chain_i[17:16]` and `chain_i[19:18]`. A counter is matched when its count after the event's increment equals its match value. Watchpoint 8 chains with watchpoint 7 and watchpoint 9 with watchpoint 8, using the R1 codes.
- R5: `status_o[n]` is set by an evaluated event in which watchpoint n is asserted and `brk_en_i[n]` is 1. It stays set until a cycle with `stat_clr_i[n]`=1, and a set in the same cycle wins over a clear.
- R6: `brk_req_o` is high for exactly the one cycle after an evaluated event in which at least one asserted watchpoint has its break enable set, and low otherwise.
- R7: An event is not evaluated when `dbg_en_i` is 0, when `cpu_rst_i` is 1, when `brk_en_i` and `cnt_sel_i` are both all zero, or when `mp_hit_i` is all zero. Such an event clears `wp_o` and leaves the counters, the status and the break request untouched.
- R8: Counters wrap modulo 2^16.
- R9: A counter write (`cnt_wr_i[k]`=1) in the same cycle as an evaluated event stores the written count and match values in place of the increment.
- R10: All outputs are registered. `wp_o` updates at the clock edge that samples `hit_valid_i` high and holds its value between events.
- R11: After reset, the watchpoints, the counts, the match values, the status and the break request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | One evaluation event this cycle |
| mp_hit_i | input | 8 | Matchpoint hit vector |
| chain_i | input | 20 | Two-bit chain code per watchpoint, watchpoint n at bits 2n+1:2n |
| dbg_en_i | input | 1 | Debug unit enabled |
| cpu_rst_i | input | 1 | Processor held in reset |
| cnt_en_i | input | 2 | Counter enables, bit k for counter k |
| cnt_sel_i | input | 8 | Counter assignment for watchpoints 0..7 |
| brk_en_i | input | 10 | Generate-break enable per watchpoint |
| stat_clr_i | input | 10 | Write-one-to-clear for status bits |
| cnt_wr_i | input | 2 | Counter write strobe, bit k for counter k |
| cnt_wr_count_i | input | 16 | Count value to write |
| cnt_wr_match_i | input | 16 | Match value to write |
| wp_o | output | 10 | Watchpoint flags of the last event |
| cnt_count_o | output | 32 | Counter 1 count in bits 31:16, counter 0 in 15:0 |
| cnt_match_o | output | 32 | Counter 1 match in bits 31:16, counter 0 in 15:0 |
| status_o | output | 10 | Sticky breakpoint status |
| brk_req_o | output | 1 | Break request pulse |

## Verification
A wrong count becomes visible on `cnt_count_o` one cycle after the event that produced it. The same fault also reaches `wp_o[9:8]` once the count next lines up with, or misses, its match value. A chain stage that is wired wrong or decodes its code wrongly corrupts every later watchpoint that ORs or ANDs with it. It therefore shows on `wp_o` in the cycle after the event. Lost stickiness or a missed set shows on `status_o` at once and stays visible for as long as the bit should hold.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int NUM_CNT = 2;

  typedef enum logic [1:0] {
    CH_NONE = 2'b00,
    CH_AND  = 2'b01,
    CH_OR   = 2'b10,
    CH_RSVD = 2'b11
  } chain_e;
endpackage

// File: rtl/wpc_link.sv
module wpc_link
  import wpc_pkg::*;
#(
  parameter bit HAS_PREV = 1'b1
) (
  input  logic       own_i,
  input  logic       prev_i,
  input  logic [1:0] code_i,
  output logic       wp_o
);
  chain_e code;
  logic   comb;

  assign code = chain_e'(code_i);

  always_comb begin
    unique case (code)
      CH_NONE: comb = own_i;
      CH_AND:  comb = own_i & prev_i;
      CH_OR:   comb = own_i | prev_i;
      default: comb = 1'b0;
    endcase
    // no predecessor: only pass-through is defined
    if (!HAS_PREV && code != CH_NONE) comb = 1'b0;
  end

  assign wp_o = comb;
endmodule

// File: rtl/wpc_chain.sv
module wpc_chain #(
  parameter int N        = 8,
  parameter bit EXT_HEAD = 1'b0
) (
  input  logic [N-1:0]   own_i,
  input  logic           head_i,
  input  logic [2*N-1:0] code_i,
  output logic [N-1:0]   wp_o
);
  logic [N:0] link;

  assign link[0] = head_i;

  for (genvar i = 0; i < N; i++) begin : g_link
    localparam bit HP = (i > 0) || EXT_HEAD;
    wpc_link #(.HAS_PREV(HP)) u_link (
      .own_i (own_i[i]),
      .prev_i(link[i]),
      .code_i(code_i[2*i +: 2]),
      .wp_o  (link[i+1])
    );
  end

  assign wp_o = link[N:1];
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int NUM_HIT = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic               en_i,
  input  logic [NUM_HIT-1:0] hits_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wr_count_i,
  input  logic [CNT_W-1:0]   wr_match_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   match_o,
  output logic               matched_o
);
  localparam int INC_W = $clog2(NUM_HIT + 1);

  logic [CNT_W-1:0] count_q, match_q, count_inc;
  logic [INC_W-1:0] inc;

  always_comb begin
    inc = '0;
    for (int i = 0; i < NUM_HIT; i++) inc = inc + INC_W'(hits_i[i]);
    if (!en_i) inc = '0;
  end

  assign count_inc = count_q + CNT_W'(inc);
  assign matched_o = (count_inc == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= '0;
    end else if (wr_i) begin
      count_q <= wr_count_i;
      match_q <= wr_match_i;
    end else if (evt_i) begin
      count_q <= count_inc;
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
endmodule

// File: rtl/wp_chain_unit.sv
module wp_chain_unit
  import wpc_pkg::*;
#(
  parameter int NUM_MP   = 8,
  parameter int CNT_W    = 16,
  localparam int NUM_WP  = NUM_MP + NUM_CNT,
  localparam int CHAIN_W = 2 * NUM_WP
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hit_valid_i,
  input  logic [NUM_MP-1:0]        mp_hit_i,
  input  logic [CHAIN_W-1:0]       chain_i,
  input  logic                     dbg_en_i,
  input  logic                     cpu_rst_i,
  input  logic [NUM_CNT-1:0]       cnt_en_i,
  input  logic [NUM_MP-1:0]        cnt_sel_i,
  input  logic [NUM_WP-1:0]        brk_en_i,
  input  logic [NUM_WP-1:0]        stat_clr_i,
  input  logic [NUM_CNT-1:0]       cnt_wr_i,
  input  logic [CNT_W-1:0]         cnt_wr_count_i,
  input  logic [CNT_W-1:0]         cnt_wr_match_i,
  output logic [NUM_WP-1:0]        wp_o,
  output logic [NUM_CNT*CNT_W-1:0] cnt_count_o,
  output logic [NUM_CNT*CNT_W-1:0] cnt_match_o,
  output logic [NUM_WP-1:0]        status_o,
  output logic                     brk_req_o
);
  logic               eval;
  logic [NUM_MP-1:0]  wp_lo;
  logic [NUM_CNT-1:0] cnt_hit, wp_hi;
  logic [NUM_WP-1:0]  wp_all, brk_hits;
  logic [NUM_WP-1:0]  wp_q, status_q;
  logic               brk_q;

  assign eval = hit_valid_i & dbg_en_i & ~cpu_rst_i
              & ((|brk_en_i) | (|cnt_sel_i)) & (|mp_hit_i);

  wpc_chain #(.N(NUM_MP), .EXT_HEAD(1'b0)) u_chain_lo (
    .own_i (mp_hit_i),
    .head_i(1'b0),
    .code_i(chain_i[2*NUM_MP-1:0]),
    .wp_o  (wp_lo)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic [NUM_MP-1:0] assigned;
    assign assigned = (k == 0) ? ~cnt_sel_i : cnt_sel_i;
    wpc_counter #(.NUM_HIT(NUM_MP), .CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (eval),
      .en_i      (cnt_en_i[k]),
      .hits_i    (wp_lo & assigned),
      .wr_i      (cnt_wr_i[k]),
      .wr_count_i(cnt_wr_count_i),
      .wr_match_i(cnt_wr_match_i),
      .count_o   (cnt_count_o[k*CNT_W +: CNT_W]),
      .match_o   (cnt_match_o[k*CNT_W +: CNT_W]),
      .matched_o (cnt_hit[k])
    );
  end

  wpc_chain #(.N(NUM_CNT), .EXT_HEAD(1'b1)) u_chain_hi (
    .own_i (cnt_hit),
    .head_i(wp_lo[NUM_MP-1]),
    .code_i(chain_i[CHAIN_W-1:2*NUM_MP]),
    .wp_o  (wp_hi)
  );

  assign wp_all   = {wp_hi, wp_lo};
  assign brk_hits = eval ? (wp_all & brk_en_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q     <= '0;
      status_q <= '0;
      brk_q    <= 1'b0;
    end else begin
      if (hit_valid_i) wp_q <= eval ? wp_all : '0;
      status_q <= (status_q & ~stat_clr_i) | brk_hits;
      brk_q    <= |brk_hits;
    end
  end

  assign wp_o      = wp_q;
  assign status_o  = status_q;
  assign brk_req_o = brk_q;
endmodule

// File: rtl/wp_chain_unit_chk.sv
module wp_chain_unit_chk #(
  parameter int NUM_MP  = 8,
  parameter int CNT_W   = 16,
  parameter int NUM_WP  = 10,
  parameter int NUM_CNT = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     hit_valid_i,
  input logic [NUM_MP-1:0]        mp_hit_i,
  input logic                     dbg_en_i,
  input logic                     cpu_rst_i,
  input logic [NUM_CNT-1:0]       cnt_wr_i,
  input logic [NUM_WP-1:0]        stat_clr_i,
  input logic [NUM_WP-1:0]        wp_o,
  input logic [NUM_CNT*CNT_W-1:0] cnt_count_o,
  input logic [NUM_WP-1:0]        status_o,
  input logic                     brk_req_o
);
  AST_WP0_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !mp_hit_i[0]) |=> !wp_o[0]); // R2

  AST_CNT0_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !cnt_wr_i[0]) |=>
      (CNT_W'(cnt_count_o[CNT_W-1:0] - $past(cnt_count_o[CNT_W-1:0])) <= CNT_W'(NUM_MP))); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ($past(status_o) & ~$past(stat_clr_i)))
              == ($past(status_o) & ~$past(stat_clr_i)))); // R5

  AST_BRK_HAS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> ((status_o & wp_o) != '0)); // R6

  AST_BRK_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_valid_i |=> !brk_req_o); // R6

  AST_SKIP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && (!dbg_en_i || cpu_rst_i)) |=> (wp_o == '0)); // R7

  AST_SKIP_NO_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && mp_hit_i == '0) |=> !brk_req_o); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_valid_i && cnt_wr_i == '0) |=>
      ($stable(cnt_count_o) && $stable(wp_o))); // R10
endmodule

bind wp_chain_unit wp_chain_unit_chk #(
  .NUM_MP(NUM_MP), .CNT_W(CNT_W), .NUM_WP(NUM_WP), .NUM_CNT(wpc_pkg::NUM_CNT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hit_valid_i(hit_valid_i),
  .mp_hit_i   (mp_hit_i),
  .dbg_en_i   (dbg_en_i),
  .cpu_rst_i  (cpu_rst_i),
  .cnt_wr_i   (cnt_wr_i),
  .stat_clr_i (stat_clr_i),
  .wp_o       (wp_o),
  .cnt_count_o(cnt_count_o),
  .status_o   (status_o),
  .brk_req_o  (brk_req_o)
);

// File: tb/wp_chain_unit_bench.sv
module wp_chain_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hit_valid_i = 1'b0;
  logic [7:0]  mp_hit_i = '0;
  logic [19:0] chain_i = '0;
  logic        dbg_en_i = 1'b1;
  logic        cpu_rst_i = 1'b0;
  logic [1:0]  cnt_en_i = '0;
  logic [7:0]  cnt_sel_i = '0;
  logic [9:0]  brk_en_i = '0;
  logic [9:0]  stat_clr_i = '0;
  logic [1:0]  cnt_wr_i = '0;
  logic [15:0] cnt_wr_count_i = '0;
  logic [15:0] cnt_wr_match_i = '0;
  logic [9:0]  wp_o;
  logic [31:0] cnt_count_o;
  logic [31:0] cnt_match_o;
  logic [9:0]  status_o;
  logic        brk_req_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wp_chain_unit u_wp_chain_unit (.*);

  // {mp[7:0], chain[19:0], expected wp[9:0]}
  localparam logic [37:0] VEC [9] = '{
    {8'h01, 20'h00000, 10'h001},
    {8'hFF, 20'h00000, 10'h0FF},
    {8'h02, 20'h000A0, 10'h00E},
    {8'h04, 20'h00010, 10'h000},
    {8'h06, 20'h00010, 10'h006},
    {8'h01, 20'h00001, 10'h000},
    {8'h20, 20'h00C00, 10'h000},
    {8'h80, 20'h60000, 10'h180},
    {8'h80, 20'hA0000, 10'h380}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [7:0] mp, input logic [19:0] ch, input logic [7:0] sel,
                    input logic [1:0] en, input logic [9:0] be);
    @(negedge clk_i);
    mp_hit_i = mp; chain_i = ch; cnt_sel_i = sel; cnt_en_i = en; brk_en_i = be;
    hit_valid_i = 1'b1;
    @(negedge clk_i);
    hit_valid_i = 1'b0;
    cnt_wr_i = '0;
  endtask

  task automatic wr_cnt(input logic [1:0] which, input logic [15:0] c, input logic [15:0] m);
    @(negedge clk_i);
    cnt_wr_i = which; cnt_wr_count_i = c; cnt_wr_match_i = m;
    @(negedge clk_i);
    cnt_wr_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 wp", 32'(wp_o), 0);
    check("R11 count", cnt_count_o, 0);
    check("R11 status", 32'(status_o), 0);
    check("R11 brk", 32'(brk_req_o), 0);
    rst_ni = 1'b1;

    wr_cnt(2'b11, 16'h0000, 16'hFFFF);
    check("R11 match load", cnt_match_o, 32'hFFFF_FFFF);

    // chain table: R1 R2 R4
    for (int i = 0; i < 9; i++) begin
      ev(VEC[i][37:30], VEC[i][29:10], 8'h00, 2'b00, 10'h3FF);
      check($sformatf("R1/R2/R4 vec%0d wp", i), 32'(wp_o), 32'(VEC[i][9:0]));
      check($sformatf("R6 vec%0d brk", i), 32'(brk_req_o), 32'(VEC[i][9:0] != 0));
    end

    // R5 sticky accumulation and clear
    check("R5 accumulated", 32'(status_o), 32'h3FF);
    @(negedge clk_i); stat_clr_i = 10'h0F0;
    @(negedge clk_i); stat_clr_i = '0;
    check("R5 partial clear", 32'(status_o), 32'h30F);
    @(negedge clk_i); stat_clr_i = 10'h3FF;
    @(negedge clk_i); stat_clr_i = '0;
    check("R5 full clear", 32'(status_o), 0);

    // R4 counter-0 match lands after increment
    wr_cnt(2'b01, 16'h0000, 16'h0003);
    ev(8'h03, 20'h0, 8'h00, 2'b01, 10'h100);
    check("R3 cnt0 +2", 32'(cnt_count_o[15:0]), 2);
    check("R4 wp8 off", 32'(wp_o), 32'h003);
    check("R6 no brk", 32'(brk_req_o), 0);
    ev(8'h01, 20'h0, 8'h00, 2'b01, 10'h100);
    check("R4 wp8 on", 32'(wp_o), 32'h101);
    check("R6 brk on wp8", 32'(brk_req_o), 1);
    check("R5 status wp8", 32'(status_o), 32'h100);
    @(negedge clk_i);
    check("R6 pulse ends", 32'(brk_req_o), 0);
    check("R10 wp holds", 32'(wp_o), 32'h101);
    check("R5 holds", 32'(status_o), 32'h100);

    // R3 assignment and enables
    wr_cnt(2'b11, 16'h0000, 16'hFFFF);
    ev(8'h07, 20'h0, 8'h02, 2'b11, 10'h001);
    check("R3 cnt0 assigned", 32'(cnt_count_o[15:0]), 2);
    check("R3 cnt1 assigned", 32'(cnt_count_o[31:16]), 1);
    ev(8'h07, 20'h0, 8'h02, 2'b01, 10'h001);
    check("R3 cnt0 enabled", 32'(cnt_count_o[15:0]), 4);
    check("R3 cnt1 disabled", 32'(cnt_count_o[31:16]), 1);

    // R8 wrap
    wr_cnt(2'b01, 16'hFFFE, 16'h0000);
    ev(8'h07, 20'h0, 8'h00, 2'b01, 10'h001);
    check("R8 wrap", 32'(cnt_count_o[15:0]), 1);

    // R9 write wins over increment
    @(negedge clk_i);
    cnt_wr_i = 2'b01; cnt_wr_count_i = 16'h0010; cnt_wr_match_i = 16'h0000;
    mp_hit_i = 8'h01; chain_i = '0; cnt_sel_i = '0; cnt_en_i = 2'b01; brk_en_i = 10'h001;
    hit_valid_i = 1'b1;
    @(negedge clk_i);
    hit_valid_i = 1'b0; cnt_wr_i = '0;
    check("R9 write priority", 32'(cnt_count_o[15:0]), 32'h10);
    check("R9 wp still evaluated", 32'(wp_o), 32'h001);

    // R7 skip conditions
    dbg_en_i = 1'b0;
    ev(8'h01, 20'h0, 8'h00, 2'b01, 10'h001);
    check("R7 disabled wp", 32'(wp_o), 0);
    check("R7 disabled cnt", 32'(cnt_count_o[15:0]), 32'h10);
    check("R7 disabled brk", 32'(brk_req_o), 0);
    dbg_en_i = 1'b1;
    ev(8'h01, 20'h0, 8'h00, 2'b01, 10'h001);
    cpu_rst_i = 1'b1;
    ev(8'h01, 20'h0, 8'h00, 2'b01, 10'h001);
    check("R7 cpu reset wp", 32'(wp_o), 0);
    check("R7 cpu reset cnt", 32'(cnt_count_o[15:0]), 32'h11);
    cpu_rst_i = 1'b0;
    @(negedge clk_i); stat_clr_i = 10'h3FF;
    @(negedge clk_i); stat_clr_i = '0;
    ev(8'h01, 20'h0, 8'h00, 2'b01, 10'h000);
    check("R7 no enables wp", 32'(wp_o), 0);
    check("R7 no enables cnt", 32'(cnt_count_o[15:0]), 32'h11);
    check("R7 no enables status", 32'(status_o), 0);
    ev(8'h00, 20'h80000, 8'h00, 2'b01, 10'h3FF);
    check("R7 no hit wp", 32'(wp_o), 0);
    check("R7 no hit brk", 32'(brk_req_o), 0);

    // R11 mid-run reset
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11 count after reset", cnt_count_o, 0);
    check("R11 match after reset", cnt_match_o, 0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule